// File: doc/BRIEF.md
# Accumulator Fetch-Execute Controller

This block is a small accumulator processor core in which program and data live in one synchronous single-port RAM. Every instruction passes through an explicit register-transfer fetch: the program counter is copied into the memory address register, the addressed word is read into the memory data register, and that word then moves into the current instruction register while the program counter steps by one. The instruction is then decoded. A jump reloads the program counter from its address field and returns directly to the first fetch step. Every other instruction is executed once before the loop restarts. Only one instruction is in progress at any time.

The RAM sits outside the core. The core drives the address from its memory address register and the write data from its memory data register. Read data comes back one clock after the address is presented. A 16-bit instruction word carries a 4-bit opcode in bits 15:12 and a 12-bit address in bits 11:0. The opcodes are HALT=0, LOAD=1, STORE=2, ADD=3, SUB=4, CMP=5 and JMP=6. Opcodes 7 to 15 are unused.

Top module: `fx_core`

## Requirements
- R1: Code and data share the one RAM. `memAddr` always equals the memory address register, and read data is taken one clock after the address. A word stored into a program location is fetched and executed as an instruction when control reaches it.
- R2: The fetch runs in four states, PC to MAR, RAM read, read data to MDR, then MDR to CIR with PC+1. The opcode is CIR bits 15:12 and the address field is CIR bits 11:0.
- R3: Counted in clock edges from the first fetch step, LOAD, ADD, SUB and CMP take 8, STORE takes 7, and JMP and unused opcodes take 5. After a HALT has been fetched, `halted` rises on the 5th edge.
- R4: LOAD copies the memory operand into the accumulator. ADD and SUB add the operand to the accumulator or subtract it, modulo 2^16.
- R5: STORE copies the accumulator through the MDR to the address field. `memWe` is high for exactly one cycle, with `memWData` equal to the accumulator.
- R6: JMP loads the address field into the PC and goes straight back to fetch, with no execute state. The words after the jump are not executed.
- R7: CMP compares the accumulator with the memory operand as unsigned values. It sets `cmpFlags` to gt (bit 2), lt (bit 1) or eq (bit 0), with exactly one bit set, and leaves the accumulator unchanged. The flags hold until the next CMP.
- R8: HALT raises `halted`. From then until reset, the state is frozen, `halted` stays high and no memory write occurs.
- R9: A synchronous active-high `rst` clears the PC, accumulator, flags, MAR and MDR, drops `halted`, and enters the first fetch step, so that execution restarts at address 0.
- R10: Opcodes 7 to 15 behave as no-ops. They change neither the accumulator, the flags nor memory, and execution continues at the next address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 12 | RAM address, driven by the memory address register |
| memWData | output | 16 | RAM write data, driven by the memory data register |
| memRData | input | 16 | RAM read data, valid one clock after the address |
| memWe | output | 1 | RAM write enable |
| halted | output | 1 | High once HALT has executed, until reset |
| cmpFlags | output | 3 | Last compare result: bit 2 gt, bit 1 lt, bit 0 eq |

## Verification
The hardest case to reach from the ports is the shared-memory case, in which the program writes a word into its own instruction stream and then fetches it. The stimulus loads a STORE opcode as data, stores it into the location that follows, and expects a second write whose address comes from that freshly written instruction. Skipped code after a jump is exposed by placing a STORE there whose target must stay zero. A scoreboard tracks write order, data and the flag state at each write, and the cycle counts to halt confirm the per-instruction state sequence, including the no-op path for an unused opcode.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'd4;
  localparam logic [OPC_W-1:0] OP_CMP   = 4'd5;
  localparam logic [OPC_W-1:0] OP_JMP   = 4'd6;

  typedef enum logic [3:0] {
    ST_FMAR, ST_FRD, ST_FMDR, ST_FCIR, ST_DEC,
    ST_ORD, ST_OMDR, ST_EXEC, ST_SMDR, ST_SWR, ST_HALT
  } fxState_t;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_LOAD, ACC_ADD, ACC_SUB, ACC_CMP
  } accOp_t;

  typedef struct packed {
    logic   ldMar;
    logic   marFromPc;
    logic   ldMdr;
    logic   mdrFromAcc;
    logic   ldCir;
    logic   incPc;
    logic   ldPcJmp;
    accOp_t accOp;
    logic   memWe;
  } fxStrobe_t;
endpackage

// File: rtl/fx_ctrl.sv
module fx_ctrl
  import fx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output fxStrobe_t        strobe,
  output logic             halted
);
  fxState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FMAR;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_FMAR: nextState = ST_FRD;
      ST_FRD:  nextState = ST_FMDR;
      ST_FMDR: nextState = ST_FCIR;
      ST_FCIR: nextState = ST_DEC;
      ST_DEC: begin
        case (opcode)
          OP_HALT:  nextState = ST_HALT;
          OP_JMP:   nextState = ST_FMAR;
          OP_STORE: nextState = ST_SMDR;
          OP_LOAD, OP_ADD, OP_SUB, OP_CMP: nextState = ST_ORD;
          default:  nextState = ST_FMAR;
        endcase
      end
      ST_ORD:  nextState = ST_OMDR;
      ST_OMDR: nextState = ST_EXEC;
      ST_EXEC: nextState = ST_FMAR;
      ST_SMDR: nextState = ST_SWR;
      ST_SWR:  nextState = ST_FMAR;
      ST_HALT: nextState = ST_HALT;
      default: nextState = ST_FMAR;
    endcase
  end

  always_comb begin
    strobe = '0;
    strobe.accOp = ACC_NONE;
    unique case (state)
      ST_FMAR: begin
        strobe.ldMar     = 1'b1;
        strobe.marFromPc = 1'b1;
      end
      ST_FMDR: strobe.ldMdr = 1'b1;
      ST_FCIR: begin
        strobe.ldCir = 1'b1;
        strobe.incPc = 1'b1;
      end
      ST_DEC: begin
        if (opcode == OP_JMP) strobe.ldPcJmp = 1'b1;
        else if (opcode inside {OP_LOAD, OP_STORE, OP_ADD, OP_SUB, OP_CMP})
          strobe.ldMar = 1'b1;
      end
      ST_OMDR: strobe.ldMdr = 1'b1;
      ST_EXEC: begin
        case (opcode)
          OP_LOAD: strobe.accOp = ACC_LOAD;
          OP_ADD:  strobe.accOp = ACC_ADD;
          OP_SUB:  strobe.accOp = ACC_SUB;
          OP_CMP:  strobe.accOp = ACC_CMP;
          default: strobe.accOp = ACC_NONE;
        endcase
      end
      ST_SMDR: begin
        strobe.ldMdr      = 1'b1;
        strobe.mdrFromAcc = 1'b1;
      end
      ST_SWR:  strobe.memWe = 1'b1;
      default: ;
    endcase
  end

  assign halted = (state == ST_HALT);

  // R8: once halted, stays halted with no writes
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !strobe.memWe));

  // R6: a decoded jump returns straight to the first fetch step
  a_r6_jump_skips_exec: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEC && opcode == OP_JMP) |=> (state == ST_FMAR));

  // R2: the fetch visits its four states in order
  a_r2_fetch_order: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FRD) |=> (state == ST_FMDR));
endmodule

// File: rtl/fx_dpath.sv
module fx_dpath
  import fx_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  fxStrobe_t         strobe,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  output logic [OPC_W-1:0]  opcode,
  output logic [2:0]        cmpFlags
);
  logic [ADDR_W-1:0] pc, mar;
  logic [DATA_W-1:0] mdr, cir, acc;
  logic [ADDR_W-1:0] addrField;

  assign addrField = cir[ADDR_W-1:0];
  assign opcode    = cir[DATA_W-1 -: OPC_W];
  assign memAddr   = mar;
  assign memWData  = mdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      mar      <= '0;
      mdr      <= '0;
      cir      <= '0;
      acc      <= '0;
      cmpFlags <= '0;
    end else begin
      if (strobe.ldMar)   mar <= strobe.marFromPc ? pc : addrField;
      if (strobe.ldMdr)   mdr <= strobe.mdrFromAcc ? acc : memRData;
      if (strobe.ldCir)   cir <= mdr;
      if (strobe.incPc)   pc  <= pc + 1'b1;
      if (strobe.ldPcJmp) pc  <= addrField;
      unique case (strobe.accOp)
        ACC_LOAD: acc <= mdr;
        ACC_ADD:  acc <= acc + mdr;
        ACC_SUB:  acc <= acc - mdr;
        ACC_CMP:  cmpFlags <= {acc > mdr, acc < mdr, acc == mdr};
        default: ;
      endcase
    end
  end

  // R2: PC steps by exactly one during fetch
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    strobe.incPc |=> (pc == ADDR_W'($past(pc) + 1'b1)));

  // R2: fetched word moves from MDR into CIR
  a_r2_cir_from_mdr: assert property (@(posedge clk) disable iff (rst)
    strobe.ldCir |=> (cir == $past(mdr)));

  // R6: jump target comes from the address field
  a_r6_jump_target: assert property (@(posedge clk) disable iff (rst)
    strobe.ldPcJmp |=> (pc == $past(addrField)));

  // R7: compare leaves the accumulator alone and sets exactly one flag
  a_r7_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
    (strobe.accOp == ACC_CMP) |=> ($stable(acc) && $countones(cmpFlags) == 1));

  // R5: data written to memory is the accumulator
  a_r5_store_data: assert property (@(posedge clk) disable iff (rst)
    strobe.memWe |-> (memWData == acc));

  // R7: flags never carry more than one result
  a_r7_flags_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmpFlags));
endmodule

// File: rtl/fx_core.sv
module fx_core
  import fx_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              memWe,
  output logic              halted,
  output logic [2:0]        cmpFlags
);
  fxStrobe_t        strobe;
  logic [OPC_W-1:0] opcode;

  fx_ctrl ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .strobe (strobe),
    .halted (halted)
  );

  fx_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .memRData (memRData),
    .memAddr  (memAddr),
    .memWData (memWData),
    .opcode   (opcode),
    .cmpFlags (cmpFlags)
  );

  assign memWe = strobe.memWe;
endmodule

// File: tb/fx_core_tb_top.sv
`timescale 1ns/1ps
module fx_core_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] memAddr;
  logic [15:0] memWData;
  logic [15:0] memRData;
  logic        memWe;
  logic        halted;
  logic [2:0]  cmpFlags;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  logic [15:0] mem [0:255];
  logic        loadEn = 1'b0;
  logic        clrMem = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [15:0] loadData = '0;

  typedef struct {
    logic [11:0] addr;
    logic [15:0] data;
    logic [2:0]  flags;
    string       req;
  } wrItem_t;
  wrItem_t expQ[$];

  always #4 clk = ~clk;

  fx_core dut_i (
    .clk(clk), .rst(rst), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memWe(memWe), .halted(halted), .cmpFlags(cmpFlags)
  );

  always @(posedge clk) begin
    if (clrMem) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (loadEn) begin
      mem[loadAddr] <= loadData;
    end else if (memWe) begin
      mem[memAddr[7:0]] <= memWData;
    end
    memRData <= mem[memAddr[7:0]];
  end

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else if (!halted) cyc <= cyc + 1;
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pokeWord(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    loadEn = 1'b1; loadAddr = a; loadData = d;
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic clearMem();
    @(negedge clk);
    clrMem = 1'b1;
    @(negedge clk);
    clrMem = 1'b0;
  endtask

  task automatic expectWrite(input logic [11:0] a, input logic [15:0] d,
                             input logic [2:0] f, input string req);
    wrItem_t it;
    it.addr = a; it.data = d; it.flags = f; it.req = req;
    expQ.push_back(it);
  endtask

  // Monitor: pops one expected item for every write the core makes
  always @(negedge clk) begin
    if (!rst && memWe) begin
      if (expQ.size() == 0) begin
        compared++;
        mismatched++;
        $display("FAIL R8 unexpected write: actual addr 0x%0h data 0x%0h expected none",
                 memAddr, memWData);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        check(it.req, "write address", int'(memAddr), int'(it.addr));
        check(it.req, "write data", int'(memWData), int'(it.data));
        check("R7", "flags at write", int'(cmpFlags), int'(it.flags));
      end
    end
  end

  task automatic checkReset();
    @(negedge clk);
    check("R9", "halted in reset", int'(halted), 0);
    check("R9", "memWe in reset", int'(memWe), 0);
    check("R9", "flags in reset", int'(cmpFlags), 0);
    check("R9", "address in reset", int'(memAddr), 0);
  endtask

  task automatic runToHalt();
    @(negedge clk);
    rst = 1'b0;
    while (!halted) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [11:0] frozenAddr;
    rst = 1'b1;
    clearMem();
    // Program 1: arithmetic, compare, jump, self-modifying store, halt
    pokeWord(8'h00, 16'h1080); // LOAD 80
    pokeWord(8'h01, 16'h3081); // ADD 81
    pokeWord(8'h02, 16'h2090); // STORE 90
    pokeWord(8'h03, 16'h4082); // SUB 82
    pokeWord(8'h04, 16'h2091); // STORE 91
    pokeWord(8'h05, 16'h5081); // CMP 81
    pokeWord(8'h06, 16'h2092); // STORE 92
    pokeWord(8'h07, 16'h600A); // JMP 0A
    pokeWord(8'h08, 16'h2093); // skipped
    pokeWord(8'h0A, 16'h1083); // LOAD 83
    pokeWord(8'h0B, 16'h5083); // CMP 83
    pokeWord(8'h0C, 16'h5084); // CMP 84
    pokeWord(8'h0D, 16'h2094); // STORE 94
    pokeWord(8'h0E, 16'h1085); // LOAD 85
    pokeWord(8'h0F, 16'h2010); // STORE 10 (into code)
    pokeWord(8'h10, 16'h0000); // becomes STORE 96
    pokeWord(8'h11, 16'h0000); // HALT
    pokeWord(8'h12, 16'h2095); // never reached
    pokeWord(8'h80, 16'h0005);
    pokeWord(8'h81, 16'h0003);
    pokeWord(8'h82, 16'hFFFF);
    pokeWord(8'h83, 16'h1234);
    pokeWord(8'h84, 16'h8000);
    pokeWord(8'h85, 16'h2096);
    checkReset();

    expectWrite(12'h090, 16'h0008, 3'b000, "R4");
    expectWrite(12'h091, 16'h0009, 3'b000, "R4");
    expectWrite(12'h092, 16'h0009, 3'b100, "R7");
    expectWrite(12'h094, 16'h1234, 3'b010, "R5");
    expectWrite(12'h010, 16'h2096, 3'b010, "R1");
    expectWrite(12'h096, 16'h2096, 3'b010, "R1");
    runToHalt();

    check("R3", "edges to halt, program 1", cyc, 116);
    check("R7", "final flags lt", int'(cmpFlags), 3'b010);
    check("R6", "skipped store target", int'(mem[8'h93]), 0);
    check("R1", "self-written instruction", int'(mem[8'h10]), 16'h2096);
    check("R5", "pending writes", expQ.size(), 0);

    frozenAddr = memAddr;
    repeat (20) @(negedge clk);
    check("R8", "halted holds", int'(halted), 1);
    check("R8", "address frozen", int'(memAddr), int'(frozenAddr));
    check("R8", "word after halt untouched", int'(mem[8'h95]), 0);

    // Program 2: reset clears acc and flags, unused opcode is a no-op
    rst = 1'b1;
    clearMem();
    pokeWord(8'h00, 16'h20A0); // STORE A0 -> 0
    pokeWord(8'h01, 16'h50A1); // CMP A1 (0) -> eq
    pokeWord(8'h02, 16'hF123); // unused opcode
    pokeWord(8'h03, 16'h20A2); // STORE A2 -> 0
    pokeWord(8'h04, 16'h0000); // HALT
    checkReset();
    expectWrite(12'h0A0, 16'h0000, 3'b000, "R9");
    expectWrite(12'h0A2, 16'h0000, 3'b001, "R10");
    runToHalt();

    check("R10", "edges to halt, program 2", cyc, 32);
    check("R10", "pending writes", expQ.size(), 0);
    check("R10", "no-op operand untouched", int'(mem[8'h23]), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule